// File: doc/BRIEF.md
# Clock Output Bank Mode Controller

This block drives sixteen clock outputs and one reference output, each with its own enable that stands for its tri-state control. It works from a fast sampling clock. Two slower clock waveforms arrive as inputs: one from an external synthesizer and one reference. A 2-bit bank mode input decides which outputs run at the full rate, which run at half rate, and whether everything is switched off. A 3-bit source select input picks the full-rate source. Code 000 selects a bypass that uses the reference divided by two. Every other code uses the synthesizer waveform.

The half-rate waveform comes from a toggle stage that steps on rising edges of the full-rate waveform, so its edges line up with full-rate edges. Both control inputs pass through a two-stage synchronizer. A new bank mode takes effect only at the point where the half-rate waveform falls, so no output sees a shortened pulse when the grouping changes. Every output is registered in the same stage, which keeps the full-rate and half-rate banks aligned with each other.

Top module: `clk_bank_ctl`

## Requirements
- R1: While reset is high, and on the first sample after it is released, every `ck_oe` bit, every `ck_o` bit and `ref_oe` are 0.
- R2: Bank mode 00 clears all sixteen `ck_oe` bits and `ref_oe`, and holds `ck_o` and `ref_o` at 0.
- R3: Bank mode 01 runs outputs 1 to 12 (bits 0..11) at full rate and outputs 13 to 16 (bits 12..15) at half rate, all enabled.
- R4: Bank mode 10 runs outputs 5 to 12 (bits 4..11) at full rate and outputs 1 to 4 and 13 to 16 (bits 0..3 and 12..15) at half rate, all enabled.
- R5: Bank mode 11 runs all sixteen outputs at full rate, all enabled.
- R6: Bits 4..11 are enabled and run at full rate in every bank mode except 00.
- R7: With source select 000, the full-rate waveform toggles on each rising edge of `ref_ck`, so it is the reference divided by two, and half-rate outputs carry the reference divided by four.
- R8: With any source select other than 000, each full-rate output equals `syn_ck` as sampled two `clk` edges earlier.
- R9: `ref_o` equals `ref_ck` as sampled two `clk` edges earlier and is never divided; `ref_oe` is 1 in every bank mode except 00.
- R10: Every rising edge of a half-rate output falls in the same `clk` cycle as a rising edge of the full-rate outputs.
- R11: A change between two non-zero bank modes, with the source select held, takes effect only in the cycle where the half-rate waveform falls. It never gives any output a high pulse shorter than the full-rate high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| syn_ck | input | 1 | Full-rate waveform from the external synthesizer |
| ref_ck | input | 1 | Reference waveform |
| mode_i | input | 2 | Bank mode (asynchronous, synchronized inside) |
| sel_i | input | 3 | Source select; 000 picks the divide-by-two bypass |
| ck_o | output | 16 | Clock outputs; bit i is output i+1 |
| ck_oe | output | 16 | Per-output drive enable (1 = driven, 0 = high impedance) |
| ref_o | output | 1 | Buffered reference output |
| ref_oe | output | 1 | Drive enable of the reference output |

## Verification
The hardest situation to reach is a bank change whose input arrives at an unlucky phase. For example, the change lands while a full-rate output is high, just before that output is handed to the half-rate bank. To cover it, the stimulus changes the mode at each of eight consecutive phase offsets of the synthesizer waveform, for several mode pairs. It then tracks the length of every high pulse on all sixteen outputs through the switch-over. A separate sweep covers all bank modes against all source-select codes and counts rising edges per output over a fixed window.

// File: rtl/clk_bank_pkg.sv
package clk_bank_pkg;

    localparam int NUM_OUT = 16;
    localparam int LOW_END = 4;      // bits [0 : LOW_END-1] form the low bank
    localparam int MID_END = 12;     // bits [LOW_END : MID_END-1] form the core bank
    localparam int MODE_W  = 2;
    localparam int SEL_W   = 3;
    localparam int SYNC_W  = MODE_W + SEL_W;

    typedef enum logic [MODE_W-1:0] {
        BANK_OFF    = 2'b00,
        BANK_12F_4H = 2'b01,
        BANK_8F_8H  = 2'b10,
        BANK_ALL_F  = 2'b11
    } bank_mode_e;

    typedef enum logic [1:0] {
        RATE_OFF  = 2'b00,
        RATE_FULL = 2'b01,
        RATE_HALF = 2'b10
    } rate_e;

    typedef struct packed {
        bank_mode_e mode;
        logic       bypass;
    } bank_cfg_t;

    function automatic rate_e rate_of(input int idx, input bank_mode_e m);
        rate_e r;
        if (m == BANK_OFF) begin
            r = RATE_OFF;
        end else if (idx >= LOW_END && idx < MID_END) begin
            r = RATE_FULL;
        end else begin
            case (m)
                BANK_ALL_F:  r = RATE_FULL;
                BANK_12F_4H: r = (idx < MID_END) ? RATE_FULL : RATE_HALF;
                default:     r = RATE_HALF;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/clk_bank_sync.sv
module clk_bank_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/clk_bank_div.sv
module clk_bank_div (
    input  logic clk,
    input  logic rst,
    input  logic syn_ck,
    input  logic ref_ck,
    input  logic bypass,
    output logic full_lvl,
    output logic full_rise,
    output logic half_q,
    output logic half_next,
    output logic ref_buf
);
    logic syn_s, ref_s, ref_d, byp_q, full_d;
    logic ref_rise;

    assign ref_rise  = ref_s & ~ref_d;
    assign full_lvl  = bypass ? byp_q : syn_s;
    assign full_rise = full_lvl & ~full_d;
    assign half_next = half_q ^ full_rise;
    assign ref_buf   = ref_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            syn_s  <= 1'b0;
            ref_s  <= 1'b0;
            ref_d  <= 1'b0;
            byp_q  <= 1'b0;
            full_d <= 1'b0;
            half_q <= 1'b0;
        end else begin
            syn_s  <= syn_ck;
            ref_s  <= ref_ck;
            ref_d  <= ref_s;
            full_d <= full_lvl;
            if (ref_rise)  byp_q  <= ~byp_q;
            if (full_rise) half_q <= ~half_q;
        end
    end

    // R10: the half-rate toggle only rises right after a full-rate rising edge
    p_half_on_full_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(half_q) |-> $past(full_rise));

    // R7: the bypass divider only steps on a reference rising edge
    p_bypass_ref_r7: assert property (@(posedge clk) disable iff (rst)
        (byp_q != $past(byp_q)) |-> $past(ref_rise));
endmodule

// File: rtl/clk_bank_out.sv
module clk_bank_out
    import clk_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bank_mode_e         mode,
    input  logic               full_lvl,
    input  logic               half_next,
    input  logic               ref_buf,
    output logic [NUM_OUT-1:0] ck_o,
    output logic [NUM_OUT-1:0] ck_oe,
    output logic               ref_o,
    output logic               ref_oe
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        rate_e rate;
        logic  q, oe;

        assign rate = rate_of(i, mode);

        always_ff @(posedge clk) begin
            if (rst) begin
                q  <= 1'b0;
                oe <= 1'b0;
            end else begin
                oe <= (rate != RATE_OFF);
                case (rate)
                    RATE_FULL: q <= full_lvl;
                    RATE_HALF: q <= half_next;
                    default:   q <= 1'b0;
                endcase
            end
        end

        assign ck_o[i]  = q;
        assign ck_oe[i] = oe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_o  <= 1'b0;
            ref_oe <= 1'b0;
        end else begin
            ref_oe <= (mode != BANK_OFF);
            ref_o  <= (mode != BANK_OFF) ? ref_buf : 1'b0;
        end
    end
endmodule

// File: rtl/clk_bank_ctl.sv
module clk_bank_ctl
    import clk_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               syn_ck,
    input  logic               ref_ck,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [NUM_OUT-1:0] ck_o,
    output logic [NUM_OUT-1:0] ck_oe,
    output logic               ref_o,
    output logic               ref_oe
);
    logic [SYNC_W-1:0] ctl_s;
    bank_cfg_t         cfg_sync, cfg_act, cfg_use;
    logic              load;
    logic              full_lvl, full_rise, half_q, half_next, ref_buf;

    clk_bank_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({mode_i, sel_i}),
        .q   (ctl_s)
    );

    assign cfg_sync.mode   = bank_mode_e'(ctl_s[SYNC_W-1:SEL_W]);
    assign cfg_sync.bypass = (ctl_s[SEL_W-1:0] == '0);

    // switch at a half-rate falling point, or freely while all outputs are off
    assign load    = (cfg_act.mode == BANK_OFF) || (full_rise && half_q);
    assign cfg_use = load ? cfg_sync : cfg_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act <= '{mode: BANK_OFF, bypass: 1'b0};
        end else if (load) begin
            cfg_act <= cfg_sync;
        end
    end

    clk_bank_div u_div (
        .clk       (clk),
        .rst       (rst),
        .syn_ck    (syn_ck),
        .ref_ck    (ref_ck),
        .bypass    (cfg_act.bypass),
        .full_lvl  (full_lvl),
        .full_rise (full_rise),
        .half_q    (half_q),
        .half_next (half_next),
        .ref_buf   (ref_buf)
    );

    clk_bank_out u_out (
        .clk       (clk),
        .rst       (rst),
        .mode      (cfg_use.mode),
        .full_lvl  (full_lvl),
        .half_next (half_next),
        .ref_buf   (ref_buf),
        .ck_o      (ck_o),
        .ck_oe     (ck_oe),
        .ref_o     (ref_o),
        .ref_oe    (ref_oe)
    );

    // R1: outputs come out of reset disabled
    p_reset_off_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ref_oe && ck_oe == '0));

    // R2: with the reference off, every clock output is off too
    p_all_off_r2: assert property (@(posedge clk) disable iff (rst)
        !ref_oe |-> (ck_oe == '0 && ck_o == '0));

    // R6: the core bank is driven whenever the block is not switched off
    p_core_on_r6: assert property (@(posedge clk) disable iff (rst)
        ref_oe |-> (&ck_oe[MID_END-1:LOW_END]));

    // R11: a change between live modes happens only at a half-rate fall
    p_defer_r11: assert property (@(posedge clk) disable iff (rst)
        ((cfg_act.mode != $past(cfg_act.mode)) && ($past(cfg_act.mode) != BANK_OFF))
        |-> $past(full_rise && half_q));
endmodule

// File: tb/tb_clk_bank_ctl.sv
module tb_clk_bank_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        syn_ck = 1'b0;
    logic        ref_ck = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [2:0]  sel_i = 3'b001;
    logic [15:0] ck_o, ck_oe;
    logic        ref_o, ref_oe;

    int nchk = 0;
    int nfail = 0;
    int ph = 0;

    // history of the input waveforms and the outputs, updated once per sample
    logic syn_c = 0, syn_p1 = 0, syn_p2 = 0;
    logic ref_c = 0, ref_p1 = 0, ref_p2 = 0;
    logic [15:0] cur_ck = '0, prev_ck = '0;
    logic cur_ref = 0, prev_ref = 0;

    clk_bank_ctl dut (
        .clk(clk), .rst(rst), .syn_ck(syn_ck), .ref_ck(ref_ck),
        .mode_i(mode_i), .sel_i(sel_i),
        .ck_o(ck_o), .ck_oe(ck_oe), .ref_o(ref_o), .ref_oe(ref_oe)
    );

    always #5 clk = ~clk;

    // synthesizer period 4 cycles, reference period 8 cycles
    always @(posedge clk) begin
        #1;
        ph = ph + 1;
        syn_ck = ph[1];
        ref_ck = ph[2];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        syn_p2 = syn_p1; syn_p1 = syn_c; syn_c = syn_ck;
        ref_p2 = ref_p1; ref_p1 = ref_c; ref_c = ref_ck;
        prev_ck = cur_ck;  cur_ck = ck_o;
        prev_ref = cur_ref; cur_ref = ref_o;
    endtask

    // expected rate: 0 off, 1 full, 2 half (bit i is output i+1)
    function automatic int exp_rate(input int i, input int m);
        if (m == 0) return 0;
        if (i >= 4 && i < 12) return 1;
        if (m == 3) return 1;
        if (m == 1) return (i < 12) ? 1 : 2;
        return 2;
    endfunction

    function automatic string mode_tag(input int m, input int i);
        if (m == 0) return "R2";
        if (i >= 4 && i < 12) return "R6";
        if (m == 1) return "R3";
        if (m == 2) return "R4";
        return "R5";
    endfunction

    task automatic measure(input int m, input int s);
        int   rises[16];
        int   ref_r = 0;
        bit   eq_ok = 1, ref_ok = 1, off_ok = 1, coin_ok = 1;
        logic [15:0] exp_oe;
        for (int i = 0; i < 16; i++) begin
            rises[i] = 0;
            exp_oe[i] = (exp_rate(i, m) != 0);
        end
        for (int c = 0; c < 64; c++) begin
            step();
            for (int i = 0; i < 16; i++)
                if (cur_ck[i] && !prev_ck[i]) rises[i]++;
            if (cur_ref && !prev_ref) ref_r++;
            if (m == 0) begin
                off_ok &= (ck_o == '0) && (ck_oe == '0) && !ref_o && !ref_oe;
            end else begin
                ref_ok &= (ref_o == ref_p2) && ref_oe;
                for (int i = 0; i < 16; i++) begin
                    if (s != 0 && exp_rate(i, m) == 1) eq_ok &= (cur_ck[i] == syn_p2);
                    if (exp_rate(i, m) == 2 && cur_ck[i] && !prev_ck[i])
                        coin_ok &= (cur_ck[4] && !prev_ck[4]);
                end
            end
        end
        check(ck_oe == exp_oe, (m == 0) ? "R2 enables" : "R3/R4/R5 enables", ck_oe, exp_oe);
        if (m == 0) begin
            check(off_ok, "R2 all outputs off", ck_o, 0);
        end else begin
            check(ref_ok, "R9 reference copy", ref_o, ref_p2);
            check((ref_r >= 7) && (ref_r <= 9), "R9 reference rate", ref_r, 8);
            check(coin_ok, "R10 half edge on full edge", 0, 1);
            if (s != 0) check(eq_ok, "R8 full follows synthesizer", 0, 1);
            for (int i = 0; i < 16; i++) begin
                int e;
                e = (s == 0) ? 4 : 16;
                if (exp_rate(i, m) == 2) e = e / 2;
                check((rises[i] >= e - 1) && (rises[i] <= e + 1),
                      (s == 0) ? "R7 bypass rate" : mode_tag(m, i), rises[i], e);
            end
        end
    endtask

    task automatic switch_test(input int from_m, input int to_m, input int off);
        int run[16];
        bit seen_low[16];
        bit ok = 1;
        logic [15:0] exp_oe;
        mode_i = from_m[1:0];
        repeat (48) step();
        repeat (off) step();
        mode_i = to_m[1:0];
        for (int i = 0; i < 16; i++) begin
            run[i] = 0;
            seen_low[i] = 0;
            exp_oe[i] = (exp_rate(i, to_m) != 0);
        end
        for (int c = 0; c < 48; c++) begin
            step();
            for (int i = 0; i < 16; i++) begin
                if (cur_ck[i]) run[i]++;
                else begin
                    if (seen_low[i] && run[i] > 0 && run[i] < 2) ok = 0;
                    run[i] = 0;
                    seen_low[i] = 1;
                end
            end
        end
        check(ok, "R11 no short pulse at mode change", 0, 1);
        check(ck_oe == exp_oe, "R11 new mode applied", ck_oe, exp_oe);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        finish_up();
    end

    initial begin
        repeat (4) step();
        check(ck_oe == '0 && ck_o == '0 && !ref_oe, "R1 state during reset", {ck_oe, ck_o}, 0);
        rst = 1'b0;
        step();
        check(ck_oe == '0 && !ref_oe, "R1 first sample after reset", ck_oe, 0);

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 8; s++) begin
                mode_i = m[1:0];
                sel_i  = s[2:0];
                repeat (80) step();
                measure(m, s);
            end
        end

        sel_i = 3'b001;
        for (int off = 0; off < 8; off++) begin
            switch_test(3, 1, off);
            switch_test(2, 1, off);
            switch_test(1, 2, off);
        end

        finish_up();
    end
endmodule